// File: doc/BRIEF.md
# Wake Source Attribution Unit

This unit sits beside a LIN master's bus interface and decides which wake requests are genuine, and what caused each one. Three sources can request a wake: a bus activity comparator, a local wake pin and an on-chip wake timer. The comparator and local pins are asynchronous. Each passes through a two-flop synchronizer. Bus activity counts as a wake only when a dominant episode lasts at least a programmable debounce time and no longer than a programmable filter window. A short spike is rejected, and so is an episode that looks like a stuck-dominant bus.

Each accepted wake resolves to one code from a fixed three-value enumeration. The code is latched for firmware, and one counter is incremented for the winning source. A timestamped record is pushed into a small event log, which firmware drains through a valid/ready stream port. If no new bus activity follows a bus wake within a programmable confirm interval, that wake is counted as false.

The unit also counts bus activity over fixed-length windows. Each window carries an incrementing identifier, and log records carry that identifier.

Log back-pressure: a record is presented on `log_valid_o` and is held stable until it is taken in a cycle where `log_valid_o` and `log_ready_i` are both high. When the log is full, new records are dropped and a sticky overflow bit is set. The data path never stalls.

Top module: `wake_attrib`

## Requirements
- R1: An accepted wake carries a reason code from a fixed set: bus = 0, local = 1, timer = 2. Code 3 is never produced.
- R2: A synchronized bus episode shorter than `cfg_deb_i` cycles is rejected. An episode of exactly `cfg_deb_i` cycles is accepted, provided it is within the R3 limit.
- R3: A bus episode is accepted only when its length is at most `cfg_win_i` cycles. It is accepted at the cycle it ends, and longer episodes are rejected.
- R4: When several sources qualify in the same cycle, the winner is local, then timer, then bus. Only the winner's code is latched and only the winner's counter is incremented. `multi_o` is latched high with that code.
- R5: While `reason_valid_o` is high, `reason_o` and `multi_o` hold their values even if further wakes arrive. A one-cycle `reason_clr_i` pulse drops `reason_valid_o`.
- R6: There is one wake counter per source and one false-wake counter. Each rises by one per event and saturates at all ones.
- R7: A bus wake is counted as false when no rising edge of synchronized bus activity follows it within `cfg_confirm_i` cycles. A rising edge inside that interval confirms the wake, and the false counter is not incremented.
- R8: Rising edges of bus activity are counted over windows of `ACT_LEN` cycles. At the end of each window, `act_count_o` shows the completed window's count and `win_id_o` increases by one.
- R9: Every accepted wake pushes one log record, in arrival order. The record holds a free-running cycle timestamp, the reason code, the window identifier current at acceptance, and the multi flag.
- R10: Log records follow valid/ready rules and stay stable while stalled. A record arriving when the log holds `LOG_DEPTH` entries is dropped and sets `log_ovf_o`. That bit stays set until `log_ovf_clr_i` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_act_i | input | 1 | Asynchronous bus comparator output, high = activity |
| local_wake_i | input | 1 | Asynchronous local wake pin; its rising edge requests a wake |
| timer_wake_i | input | 1 | Synchronous one-cycle timer wake pulse |
| cfg_deb_i | input | RUN_W | Minimum bus episode length in cycles |
| cfg_win_i | input | RUN_W | Maximum bus episode length in cycles |
| cfg_confirm_i | input | CONF_W | Confirm interval for bus wakes in cycles |
| reason_clr_i | input | 1 | Clears the latched reason |
| reason_valid_o | output | 1 | A reason is latched |
| reason_o | output | 2 | Latched reason code |
| multi_o | output | 1 | More than one source qualified for the latched wake |
| cnt_bus_o | output | CNT_W | Bus wake count |
| cnt_local_o | output | CNT_W | Local wake count |
| cnt_timer_o | output | CNT_W | Timer wake count |
| cnt_false_o | output | CNT_W | False bus wake count |
| act_count_o | output | ACT_W | Bus rising edges counted in the last completed window |
| win_id_o | output | WID_W | Current activity window identifier |
| log_valid_o | output | 1 | Log record available |
| log_ready_i | input | 1 | Consumer takes the record |
| log_ts_o | output | TS_W | Record timestamp |
| log_reason_o | output | 2 | Record reason code |
| log_win_o | output | WID_W | Record window identifier |
| log_multi_o | output | 1 | Record multi-source flag |
| log_ovf_o | output | 1 | Sticky log overflow |
| log_ovf_clr_i | input | 1 | Clears the overflow bit |

## Verification
Bus episodes are driven at lengths on both sides of the debounce and filter-window limits. The cases at exactly `cfg_deb_i`, one below it, exactly `cfg_win_i` and one above it show where each bound sits. A bus wake followed by a short sub-debounce spike is set against a bus wake followed by silence, which separates confirmation from false classification. A local and a timer request placed in the same cycle expose the priority order and the multi flag. A seeded random mix of local, timer and bus episodes of random length is checked against a bench model of acceptance, codes and counters. Timer bursts are used to fill the log past its depth and to drive a counter to saturation.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    WK_BUS   = 2'd0,
    WK_LOCAL = 2'd1,
    WK_TIMER = 2'd2
  } wake_src_e;

  localparam int NUM_SRC = 3;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_i[g];
        s2 <= s1;
      end
    end
    assign q_o[g] = s2;
  end
endmodule

// File: rtl/bus_qual.sv
module bus_qual #(
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_s_i,
  input  logic [RUN_W-1:0] cfg_deb_i,
  input  logic [RUN_W-1:0] cfg_win_i,
  output logic             qual_o,
  output logic             rise_o
);
  logic             bus_d;
  logic [RUN_W-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_d <= 1'b0;
      run   <= '0;
    end else begin
      bus_d <= bus_s_i;
      if (bus_s_i) begin
        if (run != '1) run <= run + 1'b1;
      end else begin
        run <= '0;
      end
    end
  end

  assign rise_o = bus_s_i & ~bus_d;
  // episode ends this cycle: length is in run
  assign qual_o = ~bus_s_i & (run != '0) & (run >= cfg_deb_i) & (run <= cfg_win_i);

  // R3: episode length resets once activity is gone
  assert_run_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_s_i |=> run == '0);
  // R2: a wake is only ever produced after activity was seen on the previous cycle
  assert_qual_after_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
    qual_o |-> $past(bus_s_i));
endmodule

// File: rtl/act_window.sv
module act_window #(
  parameter int ACT_LEN = 256,
  parameter int ACT_W   = 8,
  parameter int WID_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  output logic [ACT_W-1:0] count_o,
  output logic [WID_W-1:0] id_o
);
  localparam int TK_W = (ACT_LEN > 1) ? $clog2(ACT_LEN) : 1;
  localparam logic [TK_W-1:0] LAST = TK_W'(ACT_LEN - 1);

  logic [TK_W-1:0]  tick;
  logic [ACT_W-1:0] acc;
  logic [ACT_W-1:0] acc_nxt;

  always_comb begin
    acc_nxt = acc;
    if (rise_i && acc != '1) acc_nxt = acc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick    <= '0;
      acc     <= '0;
      count_o <= '0;
      id_o    <= '0;
    end else if (tick == LAST) begin
      tick    <= '0;
      acc     <= '0;
      count_o <= acc_nxt;
      id_o    <= id_o + 1'b1;
    end else begin
      tick <= tick + 1'b1;
      acc  <= acc_nxt;
    end
  end

  // R8: window identifier only ever steps by one
  assert_winid_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(id_o) |-> (id_o - $past(id_o)) == WID_W'(1));
endmodule

// File: rtl/event_fifo.sv
module event_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o,
  output logic         ovf_o,
  input  logic         ovf_clr_i
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic         full, empty, do_push, do_pop;

  assign empty   = (wp == rp);
  assign full    = (wp[AW-1:0] == rp[AW-1:0]) && (wp[AW] != rp[AW]);
  assign do_push = push_i && !full;
  assign do_pop  = valid_o && ready_i;
  assign valid_o = !empty;
  assign data_o  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp[AW-1:0]] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      if (push_i && full) ovf_o <= 1'b1;
      else if (ovf_clr_i) ovf_o <= 1'b0;
    end
  end

  // R10: a stalled record stays put
  assert_log_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(data_o));
  // R10: overflow is sticky until cleared
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && !ovf_clr_i |=> ovf_o);
endmodule

// File: rtl/wake_attrib.sv
module wake_attrib
  import wake_pkg::*;
#(
  parameter int RUN_W     = 8,
  parameter int CONF_W    = 12,
  parameter int CNT_W     = 8,
  parameter int ACT_LEN   = 256,
  parameter int ACT_W     = 8,
  parameter int WID_W     = 8,
  parameter int TS_W      = 16,
  parameter int LOG_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_act_i,
  input  logic              local_wake_i,
  input  logic              timer_wake_i,
  input  logic [RUN_W-1:0]  cfg_deb_i,
  input  logic [RUN_W-1:0]  cfg_win_i,
  input  logic [CONF_W-1:0] cfg_confirm_i,
  input  logic              reason_clr_i,
  output logic              reason_valid_o,
  output logic [1:0]        reason_o,
  output logic              multi_o,
  output logic [CNT_W-1:0]  cnt_bus_o,
  output logic [CNT_W-1:0]  cnt_local_o,
  output logic [CNT_W-1:0]  cnt_timer_o,
  output logic [CNT_W-1:0]  cnt_false_o,
  output logic [ACT_W-1:0]  act_count_o,
  output logic [WID_W-1:0]  win_id_o,
  output logic              log_valid_o,
  input  logic              log_ready_i,
  output logic [TS_W-1:0]   log_ts_o,
  output logic [1:0]        log_reason_o,
  output logic [WID_W-1:0]  log_win_o,
  output logic              log_multi_o,
  output logic              log_ovf_o,
  input  logic              log_ovf_clr_i
);
  localparam int LW = TS_W + 2 + WID_W + 1;

  // synchronizers: bit 0 bus, bit 1 local
  logic [1:0] syn;
  wake_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({local_wake_i, bus_act_i}),
    .q_o   (syn)
  );

  logic bus_q, bus_rise;
  bus_qual #(.RUN_W(RUN_W)) u_bq (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_s_i   (syn[0]),
    .cfg_deb_i (cfg_deb_i),
    .cfg_win_i (cfg_win_i),
    .qual_o    (bus_q),
    .rise_o    (bus_rise)
  );

  act_window #(.ACT_LEN(ACT_LEN), .ACT_W(ACT_W), .WID_W(WID_W)) u_aw (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_i  (bus_rise),
    .count_o (act_count_o),
    .id_o    (win_id_o)
  );

  logic local_d, local_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) local_d <= 1'b0;
    else        local_d <= syn[1];
  end
  assign local_q = syn[1] & ~local_d;

  // arbitration
  logic [NUM_SRC-1:0] hits;
  wake_src_e          win_src;
  logic               accept, multi_now;
  assign hits      = {timer_wake_i, local_q, bus_q};
  assign accept    = |hits;
  assign multi_now = ($countones(hits) > 1);

  always_comb begin
    if (local_q)           win_src = WK_LOCAL;
    else if (timer_wake_i) win_src = WK_TIMER;
    else                   win_src = WK_BUS;
  end

  // reason latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reason_valid_o <= 1'b0;
      reason_o       <= WK_BUS;
      multi_o        <= 1'b0;
    end else if (accept && (!reason_valid_o || reason_clr_i)) begin
      reason_valid_o <= 1'b1;
      reason_o       <= win_src;
      multi_o        <= multi_now;
    end else if (reason_clr_i) begin
      reason_valid_o <= 1'b0;
    end
  end

  // per-source counters, index = reason code
  logic [CNT_W-1:0] src_cnt [NUM_SRC];
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_cnt[g] <= '0;
      else if (accept && (win_src == wake_src_e'(g)) && (src_cnt[g] != '1))
        src_cnt[g] <= src_cnt[g] + 1'b1;
    end
  end
  assign cnt_bus_o   = src_cnt[0];
  assign cnt_local_o = src_cnt[1];
  assign cnt_timer_o = src_cnt[2];

  // false-wake classification
  logic              pend;
  logic [CONF_W-1:0] conf_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend        <= 1'b0;
      conf_cnt    <= '0;
      cnt_false_o <= '0;
    end else if (accept && win_src == WK_BUS) begin
      pend     <= 1'b1;
      conf_cnt <= cfg_confirm_i;
    end else if (pend) begin
      if (bus_rise) begin
        pend <= 1'b0;
      end else if (conf_cnt == '0) begin
        pend <= 1'b0;
        if (cnt_false_o != '1) cnt_false_o <= cnt_false_o + 1'b1;
      end else begin
        conf_cnt <= conf_cnt - 1'b1;
      end
    end
  end

  // timestamp
  logic [TS_W-1:0] ts;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts <= '0;
    else        ts <= ts + 1'b1;
  end

  logic [LW-1:0] log_in, log_out;
  assign log_in = {ts, win_src, win_id_o, multi_now};

  event_fifo #(.DEPTH(LOG_DEPTH), .W(LW)) u_log (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (accept),
    .data_i    (log_in),
    .valid_o   (log_valid_o),
    .ready_i   (log_ready_i),
    .data_o    (log_out),
    .ovf_o     (log_ovf_o),
    .ovf_clr_i (log_ovf_clr_i)
  );
  assign {log_ts_o, log_reason_o, log_win_o, log_multi_o} = log_out;

  // R1: only defined codes appear
  assert_reason_enum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reason_valid_o |-> reason_o != 2'd3);
  // R4: a local request always wins when the latch is free
  assert_local_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    local_q && (!reason_valid_o || reason_clr_i) |=> reason_o == WK_LOCAL && reason_valid_o);
  // R5: latched reason holds until cleared
  assert_reason_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reason_valid_o && !reason_clr_i |=> reason_valid_o && $stable(reason_o) && $stable(multi_o));
  // R6: counters step by at most one
  assert_bus_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_bus_o) |-> (cnt_bus_o - $past(cnt_bus_o)) == CNT_W'(1));
  // R7: false count moves only while a bus wake awaits confirmation
  assert_false_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_false_o) |-> $past(pend));
endmodule

// File: tb/wake_attrib_test.sv
`timescale 1ns/1ps
module wake_attrib_test;
  localparam int DEB = 4;
  localparam int WIN = 20;
  localparam int CONF = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_act = 1'b0, local_wake = 1'b0, timer_wake = 1'b0;
  logic reason_clr = 1'b0, log_ready = 1'b0, ovf_clr = 1'b0;
  logic reason_valid, multi, log_valid, log_multi, log_ovf;
  logic [1:0] reason, log_reason;
  logic [7:0] cnt_bus, cnt_local, cnt_timer, cnt_false, act_count, win_id, log_win;
  logic [15:0] log_ts;

  always #5 clk = ~clk;

  wake_attrib uut (
    .clk(clk), .rst_n(rst_n), .bus_act_i(bus_act), .local_wake_i(local_wake),
    .timer_wake_i(timer_wake), .cfg_deb_i(8'(DEB)), .cfg_win_i(8'(WIN)),
    .cfg_confirm_i(12'(CONF)), .reason_clr_i(reason_clr),
    .reason_valid_o(reason_valid), .reason_o(reason), .multi_o(multi),
    .cnt_bus_o(cnt_bus), .cnt_local_o(cnt_local), .cnt_timer_o(cnt_timer),
    .cnt_false_o(cnt_false), .act_count_o(act_count), .win_id_o(win_id),
    .log_valid_o(log_valid), .log_ready_i(log_ready), .log_ts_o(log_ts),
    .log_reason_o(log_reason), .log_win_o(log_win), .log_multi_o(log_multi),
    .log_ovf_o(log_ovf), .log_ovf_clr_i(ovf_clr)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int e_reason [16];
  int e_ts [16];
  int e_win [16];
  int e_multi [16];
  int exp_bus = 0, exp_local = 0, exp_timer = 0, exp_false = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit bus_ok(input int len);
    return (len >= DEB) && (len <= WIN);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_pulse(input int len);
    @(negedge clk); bus_act = 1'b1;
    repeat (len) @(negedge clk);
    bus_act = 1'b0;
  endtask

  task automatic timer_pulse();
    @(negedge clk); timer_wake = 1'b1;
    @(negedge clk); timer_wake = 1'b0;
  endtask

  task automatic local_pulse();
    @(negedge clk); local_wake = 1'b1;
    repeat (3) @(negedge clk);
    local_wake = 1'b0;
  endtask

  task automatic clear_reason();
    @(negedge clk); reason_clr = 1'b1;
    @(negedge clk); reason_clr = 1'b0;
  endtask

  task automatic drain(output int n);
    n = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      log_ready = 1'b0;
      if (!log_valid) break;
      e_reason[n] = int'(log_reason);
      e_ts[n]     = int'(log_ts);
      e_win[n]    = int'(log_win);
      e_multi[n]  = int'(log_multi);
      n++;
      log_ready = 1'b1;
    end
    @(negedge clk);
    log_ready = 1'b0;
  endtask

  task automatic wait_win_change();
    logic [7:0] old;
    old = win_id;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (win_id != old) break;
    end
  endtask

  task automatic check_counts(input string tag);
    chk(cnt_bus == 8'(exp_bus), {tag, " R6 bus count"}, cnt_bus, exp_bus);
    chk(cnt_local == 8'(exp_local), {tag, " R6 local count"}, cnt_local, exp_local);
    chk(cnt_timer == 8'(exp_timer), {tag, " R6 timer count"}, cnt_timer, exp_timer);
    chk(cnt_false == 8'(exp_false), {tag, " R7 false count"}, cnt_false, exp_false);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    int unsigned seed;
    logic [7:0] w0;
    logic [15:0] snap;
    bit stable_ok;

    seed = $urandom(32'h5A17);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // reset state
    chk(!reason_valid, "reset reason_valid R5", reason_valid, 0);
    chk(!log_valid && !log_ovf, "reset log R10", log_valid, 0);
    chk(win_id == 0 && act_count == 0, "reset window R8", win_id, 0);
    check_counts("reset");

    // R2: one below debounce rejected
    bus_pulse(DEB - 1); idle(80);
    chk(!reason_valid, "R2 short spike rejected", reason_valid, 0);
    chk(!log_valid, "R2 no log for spike", log_valid, 0);
    // R2 exact debounce accepted, R1 bus code, R7 false after silence
    bus_pulse(DEB); idle(10);
    chk(reason_valid && reason == 2'd0, "R1 bus code 0", reason, 0);
    exp_bus++;
    idle(80); exp_false++;
    check_counts("R2/R7 silent");
    clear_reason();
    chk(!reason_valid, "R5 clear drops valid", reason_valid, 0);

    // R3: one above window rejected, exact window accepted, then confirm
    bus_pulse(WIN + 1); idle(60);
    chk(!reason_valid, "R3 long episode rejected", reason_valid, 0);
    bus_pulse(WIN); idle(5); bus_pulse(1); exp_bus++;
    idle(80);
    chk(reason_valid && reason == 2'd0, "R3 window edge accepted", reason, 0);
    check_counts("R7 confirmed");
    drain(n);
    chk(n == 2, "R9 two bus records", n, 2);
    chk(e_reason[0] == 0 && e_reason[1] == 0, "R9 bus record codes", e_reason[1], 0);
    clear_reason();

    // R5: latch holds over a later wake
    timer_pulse(); idle(4); exp_timer++;
    local_pulse(); idle(8); exp_local++;
    chk(reason_valid && reason == 2'd2, "R5 timer held over local", reason, 2);
    check_counts("R5");
    drain(n);
    chk(n == 2 && e_reason[0] == 2 && e_reason[1] == 1, "R9 arrival order", e_reason[1], 1);
    clear_reason();

    // R4: local and timer in same cycle
    @(negedge clk); local_wake = 1'b1;
    @(negedge clk);
    @(negedge clk); timer_wake = 1'b1;
    @(negedge clk); timer_wake = 1'b0;
    idle(3); local_wake = 1'b0; idle(5);
    exp_local++;
    chk(reason_valid && reason == 2'd1, "R4 local beats timer", reason, 1);
    chk(multi == 1'b1, "R4 multi flag", multi, 1);
    check_counts("R4");
    drain(n);
    chk(n == 1 && e_multi[0] == 1 && e_reason[0] == 1, "R4 log multi", e_multi[0], 1);
    clear_reason();

    // R9: timestamp spacing and window id
    wait_win_change();
    w0 = win_id;
    timer_pulse(); idle(35); timer_pulse(); exp_timer += 2;
    idle(4);
    drain(n);
    chk(n == 2, "R9 two timer records", n, 2);
    chk(e_ts[1] - e_ts[0] == 37, "R9 timestamp spacing", e_ts[1] - e_ts[0], 37);
    chk(e_win[0] == int'(w0) && e_win[1] == int'(w0), "R9 window id in record", e_win[0], w0);
    chk(e_multi[0] == 0, "R9 single source record", e_multi[0], 0);
    clear_reason();

    // R8: activity window count
    wait_win_change();
    w0 = win_id;
    for (int i = 0; i < 7; i++) begin
      bus_pulse(2); idle(2);
    end
    wait_win_change();
    chk(act_count == 8'd7, "R8 activity count", act_count, 7);
    chk(win_id == w0 + 8'd1, "R8 window id step", win_id, w0 + 1);
    chk(!reason_valid, "R2 sub-debounce pulses no wake", reason_valid, 0);

    // R10: overflow and stall
    for (int i = 0; i < 6; i++) timer_pulse();
    exp_timer += 6;
    idle(3);
    snap = log_ts;
    stable_ok = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!log_valid || log_ts != snap) stable_ok = 1'b0;
    end
    chk(stable_ok, "R10 stalled record stable", int'(log_ts), int'(snap));
    chk(log_ovf, "R10 overflow set", log_ovf, 1);
    drain(n);
    chk(n == 4, "R10 depth kept", n, 4);
    chk(log_ovf, "R10 overflow sticky", log_ovf, 1);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    chk(!log_ovf, "R10 overflow cleared", log_ovf, 0);
    check_counts("R10");
    clear_reason();

    // random episodes
    for (int ep = 0; ep < 40; ep++) begin
      int kind, len, expc;
      bit acc;
      clear_reason();
      kind = int'($urandom % 3);
      acc = 1'b1;
      expc = 0;
      if (kind == 0) begin
        local_pulse(); exp_local++; expc = 1;
      end else if (kind == 1) begin
        timer_pulse(); exp_timer++; expc = 2;
      end else begin
        len = 1 + int'($urandom % (WIN + 6));
        bus_pulse(len);
        acc = bus_ok(len);
        if (acc) begin exp_bus++; exp_false++; end
      end
      idle(80);
      chk(reason_valid == acc, "R2/R3 random accept", reason_valid, acc);
      if (acc) chk(reason == 2'(expc), "R1 random code", reason, expc);
      drain(n);
      chk(n == int'(acc), "R9 random record count", n, int'(acc));
      if (acc && n == 1) chk(e_reason[0] == expc, "R9 random record code", e_reason[0], expc);
      check_counts("random");
    end

    // R6: saturation
    for (int i = 0; i < 260; i++) timer_pulse();
    idle(4);
    chk(cnt_timer == 8'hFF, "R6 timer saturates", cnt_timer, 255);
    drain(n);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule